// File: doc/BRIEF.md
# Two-Phase Disk Idle Power Manager

This block controls the power of a hard disk that sits behind an IDE-style interface, and it decides from host bus traffic alone. Every decoded host I/O cycle is presented on `io_valid`/`io_addr`. A cycle that falls inside the disk's register window counts as disk activity and restarts idle timing. Time is measured in ticks of a one-second strobe, `tick_1s`, which is high for a single clock cycle.

After a selectable number of idle seconds the block moves the disk to standby. It raises the spin-down request and disables the interface. Ten further idle seconds take the disk fully off: drive power, controller clock and drive-side buffer are all removed, and reset is held. Disk activity during standby returns the block directly to the active state. Activity while the disk is off starts an ordered wake sequence. Power comes on with reset held. Reset is released after a fixed number of ticks. The interface and buffer are enabled one tick after that.

There are four states. ACTIVE (code 0) is the normal running state. STANDBY (1) is the disk spun down. OFF (2) is the disk unpowered. WAKING (3) is the power-up sequence. The transitions are:

- ACTIVE→STANDBY on first-phase expiry.
- STANDBY→ACTIVE on a window access.
- STANDBY→OFF on second-phase expiry.
- OFF→WAKING on a window access.
- WAKING→ACTIVE when the reset hold and release ticks complete.

Top module: `disk_idle_pm`

## Requirements
- R1: After reset the state is ACTIVE (`pm_state`=0). `spin_down_req` is 0. `if_en`, `drv_pwr_en`, `drv_rst_n`, `ctl_clk_en` and `buf_en` are all 1.
- R2: In ACTIVE, the block enters STANDBY on the N-th `tick_1s` pulse after the last window access (or after entry to ACTIVE). N comes from `tmo_sel`: indices 0 to 8 give 10×(index+1), and indices 9 to 12 give 60×(index−7), so 9 gives 120 and 12 gives 300.
- R3: `tmo_sel`=13 gives N=1800 while `ac_present`=1, and N=300 while `ac_present`=0. Indices 14 and 15 give N=300.
- R4: In STANDBY, `spin_down_req`=1 and `if_en`=0. `drv_pwr_en`, `drv_rst_n`, `ctl_clk_en` and `buf_en` stay 1.
- R5: In STANDBY, the 10th tick without a window access moves the block to OFF. In OFF every output is 0, which means drive reset is asserted (active low).
- R6: A window access is `io_valid`=1 with `io_addr` in 0x1F0..0x1F7 or equal to 0x3F6. Other addresses (for example 0x1EF, 0x1F8 and 0x3F7) have no effect. In ACTIVE an access restarts the count, and it wins over a tick in the same cycle. In STANDBY an access returns the block to ACTIVE with a fresh count.
- R7: In OFF, ticks have no effect. A window access moves the block to WAKING.
- R8: WAKING drives `drv_pwr_en`=1 and `ctl_clk_en`=1, with `if_en`=0, `buf_en`=0 and `spin_down_req`=0. `drv_rst_n` stays 0 for the first RST_HOLD_TICKS ticks (default 2) and is 1 after them. The next tick enters ACTIVE, which enables the interface and buffer. Window accesses during WAKING are ignored.
- R9: `pm_state` encodes ACTIVE=0, STANDBY=1, OFF=2 and WAKING=3.
- R10: A change of `tmo_sel` during ACTIVE takes effect at once. If the idle count already reaches the new limit, the next tick enters STANDBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1s | input | 1 | One-cycle pulse per second |
| io_valid | input | 1 | A host I/O cycle is present |
| io_addr | input | ADDR_W | Host I/O address |
| tmo_sel | input | 4 | First-phase timeout index |
| ac_present | input | 1 | External AC power present |
| spin_down_req | output | 1 | Request drive spin-down |
| if_en | output | 1 | Disk interface enable |
| drv_pwr_en | output | 1 | Drive power enable, active high |
| drv_rst_n | output | 1 | Drive reset, active low |
| ctl_clk_en | output | 1 | Disk controller clock enable |
| buf_en | output | 1 | Drive-side buffer enable |
| pm_state | output | 2 | Current state code |

## Verification
A wrong state code appears on `pm_state` and on the enable outputs in the clock cycle after the offending edge. Because of this, every cycle is compared against a behavioural model. A wrong idle count cannot be seen until it shifts a timeout, so each timeout is probed one tick before and exactly at its limit. A count that is not cleared by an access shows up as a standby entry that comes too early. A faulty wake ordering shows up as the reset release and the interface enable appearing in the wrong tick, or in the same tick.

// File: rtl/disk_pm_pkg.sv
`timescale 1ns/1ps
package disk_pm_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_STANDBY = 2'd1,
        PM_OFF     = 2'd2,
        PM_WAKING  = 2'd3
    } pm_state_t;

    typedef struct packed {
        logic spin_down;
        logic if_en;
        logic pwr_en;
        logic rst_n;
        logic clk_en;
        logic buf_en;
    } pm_drive_t;

endpackage

// File: rtl/pm_addr_decode.sv
`timescale 1ns/1ps
module pm_addr_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'h1F0,
    parameter int WIN_SIZE = 8,
    parameter int ALT_ADDR = 'h3F6
) (
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO  = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] HI  = ADDR_W'(WIN_BASE + WIN_SIZE - 1);
    localparam logic [ADDR_W-1:0] ALT = ADDR_W'(ALT_ADDR);

    logic in_window;
    logic is_alt;

    always_comb begin
        in_window = (io_addr >= LO) && (io_addr <= HI);
        is_alt    = (io_addr == ALT);
        hit       = io_valid && (in_window || is_alt);
    end
endmodule

// File: rtl/pm_timeout_sel.sv
`timescale 1ns/1ps
module pm_timeout_sel
    import disk_pm_pkg::*;
#(
    parameter int CNT_W        = 11,
    parameter int SHORT_STEP   = 10,
    parameter int LONG_STEP    = 60,
    parameter int AC_TICKS     = 1800,
    parameter int BATT_MAX_TICKS = 300
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             ac_present,
    output logic [CNT_W-1:0] limit
);
    localparam int LAST_SHORT = 8;
    localparam int LAST_LONG  = 12;
    localparam int AC_INDEX   = 13;
    localparam int LONG_BASE  = LAST_SHORT - 1;

    int idx;

    always_comb begin
        idx = int'(sel);
        if (idx <= LAST_SHORT) begin
            limit = CNT_W'((idx + 1) * SHORT_STEP);
        end else if (idx <= LAST_LONG) begin
            limit = CNT_W'((idx - LONG_BASE) * LONG_STEP);
        end else if ((idx == AC_INDEX) && ac_present) begin
            limit = CNT_W'(AC_TICKS);
        end else begin
            limit = CNT_W'(BATT_MAX_TICKS);
        end
    end
endmodule

// File: rtl/pm_idle_timer.sv
`timescale 1ns/1ps
module pm_idle_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W:0] cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        expire   = adv && !clr && (cnt_next >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || expire) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt_next[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/disk_idle_pm.sv
`timescale 1ns/1ps
module disk_idle_pm
    import disk_pm_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int CNT_W          = 11,
    parameter int IDLE2_TICKS    = 10,
    parameter int RST_HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [SEL_W-1:0]  tmo_sel,
    input  logic              ac_present,
    output logic              spin_down_req,
    output logic              if_en,
    output logic              drv_pwr_en,
    output logic              drv_rst_n,
    output logic              ctl_clk_en,
    output logic              buf_en,
    output logic [1:0]        pm_state
);
    localparam logic [CNT_W-1:0] PHASE2_LIM = CNT_W'(IDLE2_TICKS);
    localparam logic [CNT_W-1:0] WAKE_LIM   = CNT_W'(RST_HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] REL_AT     = CNT_W'(RST_HOLD_TICKS);

    pm_state_t        state_q, state_d;
    logic             hit;
    logic [CNT_W-1:0] sel_limit;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             t_clr;
    logic             t_adv;
    pm_drive_t        drv;

    pm_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .io_valid (io_valid),
        .io_addr  (io_addr),
        .hit      (hit)
    );

    pm_timeout_sel #(
        .CNT_W (CNT_W)
    ) u_tsel (
        .sel        (tmo_sel),
        .ac_present (ac_present),
        .limit      (sel_limit)
    );

    always_comb begin
        t_adv = tick_1s && (state_q != PM_OFF);
        t_clr = 1'b0;
        limit = sel_limit;
        unique case (state_q)
            PM_ACTIVE: begin
                t_clr = hit;
                limit = sel_limit;
            end
            PM_STANDBY: begin
                t_clr = hit;
                limit = PHASE2_LIM;
            end
            PM_OFF: begin
                t_clr = 1'b1;
                limit = PHASE2_LIM;
            end
            PM_WAKING: begin
                t_clr = 1'b0;
                limit = WAKE_LIM;
            end
        endcase
    end

    pm_idle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (t_clr),
        .adv    (t_adv),
        .limit  (limit),
        .cnt    (cnt),
        .expire (expire)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_ACTIVE:  if (expire) state_d = PM_STANDBY;
            PM_STANDBY: begin
                if (hit)         state_d = PM_ACTIVE;
                else if (expire) state_d = PM_OFF;
            end
            PM_OFF:     if (hit) state_d = PM_WAKING;
            PM_WAKING:  if (expire) state_d = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_ACTIVE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        drv = '0;
        unique case (state_q)
            PM_ACTIVE:  drv = '{spin_down: 1'b0, if_en: 1'b1, pwr_en: 1'b1,
                                rst_n: 1'b1, clk_en: 1'b1, buf_en: 1'b1};
            PM_STANDBY: drv = '{spin_down: 1'b1, if_en: 1'b0, pwr_en: 1'b1,
                                rst_n: 1'b1, clk_en: 1'b1, buf_en: 1'b1};
            PM_OFF:     drv = '0;
            PM_WAKING:  drv = '{spin_down: 1'b0, if_en: 1'b0, pwr_en: 1'b1,
                                rst_n: (cnt >= REL_AT), clk_en: 1'b1, buf_en: 1'b0};
        endcase
    end

    assign spin_down_req = drv.spin_down;
    assign if_en         = drv.if_en;
    assign drv_pwr_en    = drv.pwr_en;
    assign drv_rst_n     = drv.rst_n;
    assign ctl_clk_en    = drv.clk_en;
    assign buf_en        = drv.buf_en;
    assign pm_state      = state_q;

endmodule

// File: rtl/disk_idle_pm_chk.sv
`timescale 1ns/1ps
module disk_idle_pm_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_valid,
    input logic [ADDR_W-1:0] io_addr,
    input logic [1:0]        pm_state,
    input logic              spin_down_req,
    input logic              if_en,
    input logic              drv_pwr_en,
    input logic              drv_rst_n,
    input logic              ctl_clk_en,
    input logic              buf_en
);
    // R8
    pwr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_pwr_en |-> !drv_rst_n);

    // R8
    if_needs_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_en |-> (drv_rst_n && drv_pwr_en && buf_en));

    // R5
    clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clk_en || buf_en) |-> drv_pwr_en);

    // R7
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd2) |=> (pm_state == 2'd2 || pm_state == 2'd3));

    // R6
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd0 && io_valid && io_addr == ADDR_W'('h1F0)) |=> (pm_state == 2'd0));

    // R8
    rst_before_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_en) |-> $past(drv_rst_n));

    // R4
    stby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spin_down_req) |-> ($past(pm_state) == 2'd0));
endmodule

bind disk_idle_pm disk_idle_pm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_valid      (io_valid),
    .io_addr       (io_addr),
    .pm_state      (pm_state),
    .spin_down_req (spin_down_req),
    .if_en         (if_en),
    .drv_pwr_en    (drv_pwr_en),
    .drv_rst_n     (drv_rst_n),
    .ctl_clk_en    (ctl_clk_en),
    .buf_en        (buf_en)
);

// File: tb/disk_idle_pm_bench.sv
`timescale 1ns/1ps
module disk_idle_pm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1s = 1'b0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  tmo_sel = '0;
    logic        ac_present = 1'b0;
    logic        spin_down_req, if_en, drv_pwr_en, drv_rst_n, ctl_clk_en, buf_en;
    logic [1:0]  pm_state;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_st = 0;
    int m_n  = 0;

    always #10 clk = ~clk;

    disk_idle_pm u_disk_idle_pm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_1s       (tick_1s),
        .io_valid      (io_valid),
        .io_addr       (io_addr),
        .tmo_sel       (tmo_sel),
        .ac_present    (ac_present),
        .spin_down_req (spin_down_req),
        .if_en         (if_en),
        .drv_pwr_en    (drv_pwr_en),
        .drv_rst_n     (drv_rst_n),
        .ctl_clk_en    (ctl_clk_en),
        .buf_en        (buf_en),
        .pm_state      (pm_state)
    );

    // Timeout in seconds per index, from R2 and R3
    function automatic int secs_for(int s, bit ac);
        case (s)
            0: return 10;   1: return 20;   2: return 30;
            3: return 40;   4: return 50;   5: return 60;
            6: return 70;   7: return 80;   8: return 90;
            9: return 120;  10: return 180; 11: return 240;
            12: return 300;
            13: return ac ? 1800 : 300;
            default: return 300;
        endcase
    endfunction

    function automatic bit is_disk_addr(bit v, int a);
        return v && ((a >= 'h1F0 && a <= 'h1F7) || a == 'h3F6);
    endfunction

    // Behavioural reference: seconds idle and phase
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_n  = 0;
        end else begin
            bit acc;
            acc = is_disk_addr(io_valid, int'(io_addr));
            if (m_st == 0) begin
                if (acc) m_n = 0;
                else if (tick_1s) begin
                    m_n = m_n + 1;
                    if (m_n >= secs_for(int'(tmo_sel), ac_present)) begin m_st = 1; m_n = 0; end
                end
            end else if (m_st == 1) begin
                if (acc) begin m_st = 0; m_n = 0; end
                else if (tick_1s) begin
                    m_n = m_n + 1;
                    if (m_n >= 10) begin m_st = 2; m_n = 0; end
                end
            end else if (m_st == 2) begin
                if (acc) begin m_st = 3; m_n = 0; end
            end else begin
                if (tick_1s) begin
                    if (m_n >= 2) begin m_st = 0; m_n = 0; end
                    else m_n = m_n + 1;
                end
            end
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_spin, e_if, e_pwr, e_rst, e_clk, e_buf;
            int bad0;
            e_spin = (m_st == 1);
            e_if   = (m_st == 0);
            e_pwr  = (m_st != 2);
            e_rst  = (m_st == 0 || m_st == 1 || (m_st == 3 && m_n >= 2));
            e_clk  = (m_st != 2);
            e_buf  = (m_st == 0 || m_st == 1);
            bad0 = n_bad;
            n_vec++;
            cmp("R9", "pm_state", int'(pm_state), m_st);
            cmp("R4", "spin_down_req", int'(spin_down_req), e_spin);
            cmp("R8", "if_en", int'(if_en), e_if);
            cmp("R5", "drv_pwr_en", int'(drv_pwr_en), e_pwr);
            cmp("R8", "drv_rst_n", int'(drv_rst_n), e_rst);
            cmp("R5", "ctl_clk_en", int'(ctl_clk_en), e_clk);
            cmp("R5", "buf_en", int'(buf_en), e_buf);
            if (n_bad > bad0) n_bad = bad0 + 1;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        cmp(tag, what, act, exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1'b1;
            @(negedge clk);
            tick_1s = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic access(logic [15:0] a);
        io_valid = 1'b1;
        io_addr  = a;
        @(negedge clk);
        io_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic access_on_tick(logic [15:0] a);
        io_valid = 1'b1;
        io_addr  = a;
        tick_1s  = 1'b1;
        @(negedge clk);
        io_valid = 1'b0;
        tick_1s  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "pm_state", int'(pm_state), 0);
        check("R1", "enables", int'({if_en, drv_pwr_en, drv_rst_n, ctl_clk_en, buf_en}), 31);
        check("R1", "spin_down_req", int'(spin_down_req), 0);

        // R2 / R6 index 0 -> 10 ticks; access restarts count
        ticks(9);
        check("R2", "pm_state", int'(pm_state), 0);
        access(16'h01F3);
        ticks(9);
        check("R6", "pm_state after restart", int'(pm_state), 0);
        ticks(1);
        check("R2", "pm_state", int'(pm_state), 1);
        check("R4", "spin_down_req", int'(spin_down_req), 1);
        check("R4", "if_en", int'(if_en), 0);
        check("R4", "drv_pwr_en", int'(drv_pwr_en), 1);

        // R6 access in standby returns to active
        ticks(9);
        check("R5", "pm_state", int'(pm_state), 1);
        access(16'h03F6);
        check("R6", "pm_state", int'(pm_state), 0);

        // R5 second phase
        ticks(10);
        check("R2", "pm_state", int'(pm_state), 1);
        ticks(10);
        check("R5", "pm_state", int'(pm_state), 2);
        check("R5", "outputs", int'({spin_down_req, if_en, drv_pwr_en, drv_rst_n, ctl_clk_en, buf_en}), 0);

        // R7 ticks in off ignored; R6 non-window addresses ignored
        ticks(5);
        check("R7", "pm_state", int'(pm_state), 2);
        access(16'h03F7);
        access(16'h01EF);
        access(16'h01F8);
        check("R6", "pm_state", int'(pm_state), 2);

        // R7 / R8 wake sequence
        access(16'h01F7);
        check("R7", "pm_state", int'(pm_state), 3);
        check("R8", "drv_pwr_en", int'(drv_pwr_en), 1);
        check("R8", "drv_rst_n", int'(drv_rst_n), 0);
        access(16'h01F0);
        ticks(1);
        check("R8", "drv_rst_n", int'(drv_rst_n), 0);
        ticks(1);
        check("R8", "pm_state", int'(pm_state), 3);
        check("R8", "drv_rst_n", int'(drv_rst_n), 1);
        check("R8", "if_en", int'(if_en), 0);
        ticks(1);
        check("R8", "pm_state", int'(pm_state), 0);
        check("R8", "if_en", int'(if_en), 1);
        check("R8", "buf_en", int'(buf_en), 1);

        // R6 access beats a simultaneous tick
        ticks(9);
        access_on_tick(16'h01F1);
        ticks(9);
        check("R6", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R6", "pm_state", int'(pm_state), 1);
        access(16'h01F4);

        // R2 long-step index
        tmo_sel = 4'd9;
        ticks(119);
        check("R2", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R2", "pm_state", int'(pm_state), 1);
        access(16'h01F2);

        // R3 AC-gated setting
        tmo_sel = 4'd13;
        ac_present = 1'b0;
        ticks(299);
        check("R3", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R3", "pm_state", int'(pm_state), 1);
        access(16'h01F2);
        ac_present = 1'b1;
        ticks(1799);
        check("R3", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R3", "pm_state", int'(pm_state), 1);
        access(16'h01F2);
        tmo_sel = 4'd15;
        ticks(299);
        check("R3", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R3", "pm_state", int'(pm_state), 1);
        access(16'h01F5);

        // R10 selection change takes effect at once
        tmo_sel = 4'd12;
        ticks(50);
        tmo_sel = 4'd0;
        @(negedge clk);
        check("R10", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R10", "pm_state", int'(pm_state), 1);
        access(16'h01F6);

        // R2 mid-table index
        tmo_sel = 4'd4;
        ticks(49);
        check("R2", "pm_state", int'(pm_state), 0);
        ticks(1);
        check("R2", "pm_state", int'(pm_state), 1);

        finish_run();
    end
endmodule